// File: doc/BRIEF.md
# Torus Dimension-Order Route Computation

This block makes the routing decision for one router of a k-ary n-dimensional torus. For each packet header it receives, it compares the destination coordinates with the router's own coordinates. It then names exactly one output port: the plus or minus link of a single dimension, or the local ejection port. Dimensions are resolved one at a time in a fixed order, starting at dimension 0. The first dimension whose coordinates differ decides the port.

In torus mode each ring is travelled the short way round, using the wraparound link where that is shorter. In mesh mode there are no wraparound links, so the direction follows the sign of the coordinate difference. The decision is registered, and it is offered to the crossbar allocator through a valid/ready pair. A held decision stays frozen until the allocator takes it.

Top module: `torus_dor_route`

## Requirements
- R1: While reset is asserted and in the first cycle after reset, `out_valid` is 0 and `in_ready` is 1.
- R2: When the destination equals the router's coordinates in every dimension, the selected port is 0 (local ejection).
- R3: Dimensions are resolved in ascending index order. The port always belongs to the lowest-index dimension whose coordinates differ, and higher dimensions have no effect while a lower one differs.
- R4: In torus mode, with forward distance f = (dest - cur) mod K in the deciding dimension d, the port is 2*d+1 (plus) when 2*f <= K and 2*d+2 (minus) otherwise.
- R5: In torus mode with even K, a forward distance of exactly K/2 selects the plus port 2*d+1.
- R6: In mesh mode (`mesh_mode`=1), the port is 2*d+1 when dest > cur in the deciding dimension and 2*d+2 when dest < cur; no route uses a wraparound link.
- R7: A header accepted at a clock edge (`in_valid` and `in_ready` both 1) shows up with `out_valid`=1 after that edge; with no new header and `out_ready`=1, `out_valid` drops after the next edge.
- R8: While `out_valid` is 1 and `out_ready` is 0, `in_ready` is 0 and `out_port` holds its value.
- R9: Whenever `out_valid` is 1, `out_port` is at most 2*N.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mesh_mode | input | 1 | 1: mesh (no wraparound), 0: torus |
| my_coord | input | N*clog2(K) | This router's coordinates, dimension d in bits [d*W +: W] |
| in_valid | input | 1 | Header valid |
| in_ready | output | 1 | Block can accept a header |
| in_dest | input | N*clog2(K) | Destination coordinates, same layout as my_coord |
| out_valid | output | 1 | Routing decision valid |
| out_ready | input | 1 | Allocator accepts the decision |
| out_port | output | clog2(2N+1) | 0 local; 2d+1 plus, 2d+2 minus of dimension d |

## Verification
A fault in the direction logic of one dimension shows up as a wrong port code one cycle after the header is accepted. Because the sweep covers every source and destination pair in both modes, every such fault is exposed. A fault in the dimension priority shows up as a port from a higher dimension while a lower one still differs. A fault in the output register or in the handshake shows up as a changed port or a raised `in_ready` during a stall, or as a decision that arrives late or stays valid too long.

// File: rtl/torus_dor_pkg.sv
package torus_dor_pkg;
    typedef enum logic {
        DIR_MINUS = 1'b0,
        DIR_PLUS  = 1'b1
    } dir_e;
endpackage

// File: rtl/torus_dor_dim.sv
module torus_dor_dim
    import torus_dor_pkg::*;
#(
    parameter int K = 4,
    parameter int W = 2
) (
    input  logic [W-1:0] cur,
    input  logic [W-1:0] dst,
    input  logic         mesh,
    output logic         differs,
    output dir_e         dir
);
    logic [W:0]   fwd;
    logic [W+1:0] twice;

    always_comb begin
        if (dst >= cur) fwd = {1'b0, dst} - {1'b0, cur};
        else            fwd = {1'b0, dst} + (W+1)'(K) - {1'b0, cur};
        twice   = {1'b0, fwd} << 1;
        differs = (dst != cur);
        if (mesh) dir = (dst > cur) ? DIR_PLUS : DIR_MINUS;
        else      dir = (twice <= (W+2)'(K)) ? DIR_PLUS : DIR_MINUS;
    end
endmodule

// File: rtl/torus_dor_select.sv
module torus_dor_select
    import torus_dor_pkg::*;
#(
    parameter int N  = 2,
    parameter int PW = 3
) (
    input  logic [N-1:0] differs,
    input  dir_e         dir [N],
    output logic [PW-1:0] port
);
    always_comb begin
        port = '0;
        for (int d = N - 1; d >= 0; d--) begin
            if (differs[d]) begin
                port = (dir[d] == DIR_PLUS) ? PW'(2 * d + 1) : PW'(2 * d + 2);
            end
        end
    end
endmodule

// File: rtl/torus_dor_route.sv
module torus_dor_route
    import torus_dor_pkg::*;
#(
    parameter int K = 4,
    parameter int N = 2,
    localparam int W  = (K > 2) ? $clog2(K) : 1,
    localparam int CW = N * W,
    localparam int PW = $clog2(2 * N + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          mesh_mode,
    input  logic [CW-1:0] my_coord,
    input  logic          in_valid,
    output logic          in_ready,
    input  logic [CW-1:0] in_dest,
    output logic          out_valid,
    input  logic          out_ready,
    output logic [PW-1:0] out_port
);
    typedef struct packed {
        logic          valid;
        logic [PW-1:0] port;
    } state_t;

    state_t        st_d, st_q;
    logic [N-1:0]  differs;
    dir_e          dir [N];
    logic [PW-1:0] sel_port;

    for (genvar g = 0; g < N; g++) begin : g_dim
        torus_dor_dim #(.K(K), .W(W)) u_dim (
            .cur     (my_coord[g*W +: W]),
            .dst     (in_dest[g*W +: W]),
            .mesh    (mesh_mode),
            .differs (differs[g]),
            .dir     (dir[g])
        );
    end

    torus_dor_select #(.N(N), .PW(PW)) u_sel (
        .differs (differs),
        .dir     (dir),
        .port    (sel_port)
    );

    always_comb begin
        in_ready = !st_q.valid || out_ready;
        st_d     = st_q;
        if (out_ready) st_d.valid = 1'b0;
        if (in_valid && in_ready) begin
            st_d.valid = 1'b1;
            st_d.port  = sel_port;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.valid;
    assign out_port  = st_q.port;
endmodule

// File: rtl/torus_dor_check.sv
module torus_dor_check #(
    parameter int K = 4,
    parameter int N = 2,
    localparam int W  = (K > 2) ? $clog2(K) : 1,
    localparam int CW = N * W,
    localparam int PW = $clog2(2 * N + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] my_coord,
    input logic          in_valid,
    input logic          in_ready,
    input logic [CW-1:0] in_dest,
    input logic          out_valid,
    input logic          out_ready,
    input logic [PW-1:0] out_port
);
    assert_reset_idle_R1: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    assert_local_port_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && in_dest == my_coord) |=> (out_port == '0));

    assert_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> out_valid);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(out_port)));

    assert_stall_block_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |-> !in_ready);

    assert_port_range_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_port) <= 2 * N));
endmodule

bind torus_dor_route torus_dor_check #(.K(K), .N(N)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .my_coord  (my_coord),
    .in_valid  (in_valid),
    .in_ready  (in_ready),
    .in_dest   (in_dest),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_port  (out_port)
);

// File: tb/torus_dor_route_test.sv
module torus_dor_route_test;
    localparam int K  = 4;
    localparam int N  = 2;
    localparam int W  = 2;
    localparam int CW = N * W;
    localparam int PW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          mesh_mode = 1'b0;
    logic [CW-1:0] my_coord = '0;
    logic          in_valid = 1'b0;
    logic          in_ready;
    logic [CW-1:0] in_dest = '0;
    logic          out_valid;
    logic          out_ready = 1'b1;
    logic [PW-1:0] out_port;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    torus_dor_route #(.K(K), .N(N)) uut (
        .clk(clk), .rst_n(rst_n), .mesh_mode(mesh_mode), .my_coord(my_coord),
        .in_valid(in_valid), .in_ready(in_ready), .in_dest(in_dest),
        .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Expected port and the requirement the case exercises.
    function automatic int expect_port(input int cur, input int dst, input bit mesh,
                                       output string tag);
        tag = "R2";
        for (int d = 0; d < N; d++) begin
            int c = (cur >> (d * W)) % K;
            int t = (dst >> (d * W)) % K;
            if (c != t) begin
                int f = (t - c + K) % K;
                bit plus;
                if (mesh) begin
                    plus = (t > c);
                    tag  = "R6";
                end else begin
                    plus = (2 * f <= K);
                    tag  = (2 * f == K) ? "R5" : "R4";
                end
                if (d > 0) tag = {tag, "/R3"};
                return plus ? 2 * d + 1 : 2 * d + 2;
            end
        end
        return 0;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        string tag;
        int    exp;
        repeat (3) @(posedge clk);
        #1;
        check("R1 out_valid in reset", out_valid, 0);
        check("R1 in_ready in reset", in_ready, 1);
        @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk);
        #1;
        check("R1 out_valid after reset", out_valid, 0);

        // Exhaustive sweep over both modes, every source and destination.
        for (int m = 0; m < 2; m++) begin
            for (int c = 0; c < 16; c++) begin
                for (int t = 0; t < 16; t++) begin
                    @(negedge clk);
                    mesh_mode = m[0];
                    my_coord  = CW'(c);
                    in_dest   = CW'(t);
                    in_valid  = 1'b1;
                    exp = expect_port(c, t, m[0], tag);
                    @(posedge clk);
                    #1;
                    check({tag, " R7 valid"}, out_valid, 1);
                    check({tag, " port"}, out_port, exp);
                    check("R9 range", int'(out_port) <= 2 * N, 1);
                end
            end
        end

        // Drain: no new header, decision leaves after one edge.
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R7 drain", out_valid, 0);

        // Stall: decision must hold and input must block.
        @(negedge clk);
        mesh_mode = 1'b0;
        my_coord  = CW'(0);
        in_dest   = CW'(3);    // dim0 forward 3 -> minus, port 2
        in_valid  = 1'b1;
        out_ready = 1'b0;
        @(posedge clk);
        #1;
        check("R7 stall accept", out_valid, 1);
        check("R4 stall port", out_port, 2);
        check("R8 in_ready low", in_ready, 0);
        @(negedge clk);
        in_dest = CW'(1);      // would be port 1 if taken
        @(posedge clk);
        #1;
        check("R8 hold valid", out_valid, 1);
        check("R8 hold port", out_port, 2);
        @(negedge clk);
        out_ready = 1'b1;
        @(posedge clk);
        #1;
        check("R8 release takes new header", out_port, 1);
        @(negedge clk);
        in_valid = 1'b0;
        @(posedge clk);
        #1;
        check("R7 final drain", out_valid, 0);

        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule